// File: doc/BRIEF.md
# Two-Stage Three-Instruction Processor Core

This block is a small processor core. It has a program counter, a 32-word instruction store, a decoder, eight general registers and an ALU. It executes 8-bit instructions of three kinds: a move of a sign-extended 4-bit constant into a register, a register-to-register add, and a register-to-register exclusive-or. No instruction changes control flow, so the program counter steps by one every cycle and wraps around the instruction store.

Execution takes two pipeline stages. In the first stage the core fetches the instruction, decodes it and reads its operands from the register file. In the second stage the ALU computes the result and writes it back at the clock edge that ends the stage. Nothing forwards a result from the second stage to the first. An instruction whose operand was written by the instruction just before it therefore gets the value from before that write. Programs must leave one instruction between a producer and its consumer when they want the new value.

The bench loads the instruction store through a write port while reset is held. It then watches the registers through a combinational debug read port.

Top module: `tcore_top`

## Requirements
- R1: Synchronous reset clears all eight registers and the program counter to zero and empties the pipeline. No register is written at the first clock edge after reset is released.
- R2: An instruction with bit 7 = 0 writes the 4-bit constant in bits 6:3, sign-extended to 8 bits, into the register named by bits 2:0.
- R3: An instruction with bits 7:6 = 2'b10 writes (Rd + Rs) mod 256 into Rd. Rd is bits 2:0 and Rs is bits 5:3.
- R4: An instruction with bits 7:6 = 2'b11 writes Rd XOR Rs into Rd, with the same field positions as R3.
- R5: The destination always comes from bits 2:0, and the source register of add and XOR always comes from bits 5:3. Any of the eight registers may be either operand.
- R6: Operands, including the old value of Rd, are read in the first stage without bypass. An instruction reading a register written by the immediately preceding instruction sees the value from before that write.
- R7: The instruction fetched in cycle k after reset release (cycle 0 being the first) updates its register at clock edge k+2. No register changes at an edge without a write-back.
- R8: The program counter starts at 0, increments by one each cycle and wraps from 31 to 0, so the program repeats.
- R9: The debug read port returns, combinationally, the current contents of the register selected by its address.
- R10: A write on the load port stores the 8-bit word at the given instruction-store address, and that word is the instruction executed when the counter reaches that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Instruction-store write strobe |
| load_addr | input | 5 | Instruction-store write address |
| load_data | input | 8 | Instruction word to store |
| dbg_addr | input | 3 | Register index for the debug read |
| dbg_data | output | 8 | Contents of the selected register |

## Verification
Assertions check, on every cycle, the following rules:
- the pipeline is empty right after reset;
- the program counter steps by exactly one;
- a register changes only through a write-back, and that write-back lands the value presented a cycle earlier;
- a move always produces a properly sign-extended value;
- each load-port write reaches the store.

The absence of forwarding, the wrap of additions, the XOR result and the repetition of a program after 32 instructions are shown only by the bench's scenarios. These scenarios compare all eight registers after every retired instruction against a model that applies the one-instruction-stale read rule, and they also check fixed expected values.

// File: rtl/tcore_pkg.sv
`timescale 1ns/1ps
package tcore_pkg;
    localparam int INSN_W = 8;
    localparam int RIDX_W = 3;
    localparam int NREG   = 1 << RIDX_W;
    localparam int IMM_W  = 4;

    typedef enum logic [1:0] {
        OP_MOV = 2'd0,
        OP_ADD = 2'd1,
        OP_XOR = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic [INSN_W-1:0] insn);
        if (!insn[7])      return OP_MOV;
        else if (!insn[6]) return OP_ADD;
        else               return OP_XOR;
    endfunction
endpackage

// File: rtl/tcore_imem.sv
`timescale 1ns/1ps
module tcore_imem #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (load_en) mem_d[load_addr] = load_data;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];

    assert_load_lands_R10: assert property (@(posedge clk) disable iff (!rst && !load_en && 1'b0)
        load_en |=> mem_q[$past(load_addr)] == $past(load_data));
endmodule

// File: rtl/tcore_regfile.sv
`timescale 1ns/1ps
module tcore_regfile #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] dbg_addr,
    output logic [W-1:0]  dbg_data
);
    localparam int N = 1 << IW;

    logic [N-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst)        regs_d = '0;
        else if (wr_en) regs_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // reads see the contents before any write pending this cycle
    assign ra_data  = regs_q[ra_addr];
    assign rb_data  = regs_q[rb_addr];
    assign dbg_data = regs_q[dbg_addr];

    assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/tcore_alu.sv
`timescale 1ns/1ps
module tcore_alu
    import tcore_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e              op,
    input  logic [W-1:0]     dst_val,
    input  logic [W-1:0]     src_val,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     result
);
    always_comb begin
        case (op)
            OP_MOV:  result = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
            OP_ADD:  result = dst_val + src_val;
            OP_XOR:  result = dst_val ^ src_val;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/tcore_top.sv
`timescale 1ns/1ps
module tcore_top
    import tcore_pkg::*;
#(
    parameter int W      = 8,
    parameter int IMEM_AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic [IMEM_AW-1:0] load_addr,
    input  logic [INSN_W-1:0]  load_data,
    input  logic [RIDX_W-1:0]  dbg_addr,
    output logic [W-1:0]       dbg_data
);
    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic [W-1:0]      dst_val;
        logic [W-1:0]      src_val;
        logic [IMM_W-1:0]  imm;
    } exec_t;

    typedef struct packed {
        logic [IMEM_AW-1:0] pc;
        exec_t              ex;
    } state_t;

    state_t st_d, st_q;

    logic [INSN_W-1:0] insn;
    logic [W-1:0]      rd_val, rs_val, wb_data;

    tcore_imem #(.AW(IMEM_AW), .DW(INSN_W)) imem_i (
        .clk(clk), .rst(rst),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .rd_addr(st_q.pc), .rd_data(insn)
    );

    tcore_regfile #(.W(W), .IW(RIDX_W)) rf_i (
        .clk(clk), .rst(rst),
        .ra_addr(insn[2:0]), .ra_data(rd_val),
        .rb_addr(insn[5:3]), .rb_data(rs_val),
        .wr_en(st_q.ex.valid), .wr_addr(st_q.ex.rd), .wr_data(wb_data),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    tcore_alu #(.W(W)) alu_i (
        .op(st_q.ex.op), .dst_val(st_q.ex.dst_val), .src_val(st_q.ex.src_val),
        .imm(st_q.ex.imm), .result(wb_data)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.pc         = st_q.pc + 1'b1;
            st_d.ex.valid   = 1'b1;
            st_d.ex.op      = decode_op(insn);
            st_d.ex.rd      = insn[2:0];
            st_d.ex.dst_val = rd_val;
            st_d.ex.src_val = rs_val;
            st_d.ex.imm     = insn[6:3];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assert_no_wb_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !st_q.ex.valid);
    assert_pc_steps_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> st_q.pc == IMEM_AW'($past(st_q.pc) + 1'b1));
    assert_mov_sign_ext_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q.ex.valid && st_q.ex.op == OP_MOV) |->
            (wb_data[W-1:IMM_W-1] == '0 || wb_data[W-1:IMM_W-1] == '1));
endmodule

// File: tb/tcore_top_tb_top.sv
`timescale 1ns/1ps
module tcore_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [4:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [2:0] dbg_addr = '0;
    logic [7:0] dbg_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] prog [32];
    logic [7:0] cur  [8];
    logic [7:0] prev [8];

    always #4 clk = ~clk;

    tcore_top dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    function automatic logic [7:0] enc_mov(input int rd, input int imm);
        return {1'b0, 4'(imm), 3'(rd)};
    endfunction
    function automatic logic [7:0] enc_add(input int rd, input int rs);
        return {2'b10, 3'(rs), 3'(rd)};
    endfunction
    function automatic logic [7:0] enc_xor(input int rd, input int rs);
        return {2'b11, 3'(rs), 3'(rd)};
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input int i, output logic [7:0] v);
        dbg_addr = 3'(i);
        #0.2;
        v = dbg_data;
    endtask

    task automatic clear_prog();
        for (int a = 0; a < 32; a++) prog[a] = 8'h00;
    endtask

    // model: retire one instruction, operands taken from the state two retirements back
    task automatic retire(input int k);
        logic [7:0] ins, nv;
        logic [7:0] tmp [8];
        int rd, rs;
        ins = prog[k % 32];
        rd  = int'(ins[2:0]);
        rs  = int'(ins[5:3]);
        if (!ins[7])      nv = {{4{ins[6]}}, ins[6:3]};
        else if (!ins[6]) nv = prev[rd] + prev[rs];
        else              nv = prev[rd] ^ prev[rs];
        for (int i = 0; i < 8; i++) tmp[i] = cur[i];
        tmp[rd] = nv;
        for (int i = 0; i < 8; i++) begin
            prev[i] = cur[i];
            cur[i]  = tmp[i];
        end
    endtask

    task automatic compare_all(input string req);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            read_reg(i, v);
            chk(req, $sformatf("model r%0d", i), v, cur[i]);
        end
    endtask

    // hold reset, load the program, confirm cleared registers, release at a falling edge
    task automatic load_and_reset();
        logic [7:0] v;
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 32; a++) begin
            load_en = 1'b1; load_addr = 5'(a); load_data = prog[a];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            read_reg(i, v);
            chk("R1", $sformatf("reset r%0d", i), v, 8'h00);
        end
        rst = 1'b0;
    endtask

    task automatic run_prog(input int n_edges, input string req);
        for (int i = 0; i < 8; i++) begin cur[i] = '0; prev[i] = '0; end
        for (int e = 1; e <= n_edges; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e >= 2) retire(e - 2);
            compare_all(e == 1 ? "R1" : req);
        end
    endtask

    task automatic read_chk(input string req, input int i, input logic [7:0] exp);
        logic [7:0] v;
        read_reg(i, v);
        chk(req, $sformatf("r%0d", i), v, exp);
    endtask

    task automatic test_mov_R2();
        clear_prog();
        prog[0] = enc_mov(1, 7);
        prog[1] = enc_mov(2, 8);
        prog[2] = enc_mov(3, 15);
        prog[3] = enc_mov(4, 0);
        load_and_reset();
        run_prog(6, "R2");
        read_chk("R2", 1, 8'h07);
        read_chk("R2", 2, 8'hF8);
        read_chk("R2", 3, 8'hFF);
        read_chk("R9", 4, 8'h00);
    endtask

    task automatic test_add_R3();
        clear_prog();
        prog[0] = enc_mov(1, 7);
        prog[1] = enc_mov(2, 15);
        prog[4] = enc_add(1, 2);
        load_and_reset();
        run_prog(8, "R3");
        read_chk("R3", 1, 8'h06);
        read_chk("R3", 2, 8'hFF);
    endtask

    task automatic test_xor_R4();
        clear_prog();
        prog[0] = enc_mov(4, 5);
        prog[1] = enc_mov(5, 13);
        prog[4] = enc_xor(4, 5);
        prog[5] = enc_mov(7, 3);
        prog[8] = enc_add(6, 7);
        load_and_reset();
        run_prog(11, "R4");
        read_chk("R4", 4, 8'hF8);
        read_chk("R5", 6, 8'h03);
        read_chk("R5", 5, 8'hFD);
    endtask

    task automatic test_hazard_R6();
        clear_prog();
        prog[0] = enc_mov(1, 3);
        prog[1] = enc_mov(2, 5);
        prog[2] = enc_add(1, 2);
        prog[3] = enc_add(1, 2);
        load_and_reset();
        run_prog(4, "R6");
        read_chk("R6", 1, 8'h03);
        run_prog_tail();
        read_chk("R6", 1, 8'h08);
        read_chk("R7", 2, 8'h05);
    endtask

    task automatic run_prog_tail();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_wrap_R8();
        clear_prog();
        prog[0]  = enc_mov(6, 1);
        prog[31] = enc_add(7, 6);
        load_and_reset();
        run_prog(66, "R8");
        read_chk("R8", 7, 8'h02);
        read_chk("R10", 6, 8'h01);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_mov_R2();
        test_add_R3();
        test_xor_R4();
        test_hazard_R6();
        test_wrap_R8();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule